// File: doc/BRIEF.md
# Write-back update coherence controller

This block is the coherence controller of one private, direct-mapped, write-back cache in a snooping multiprocessor. Every cache on the bus keeps its copies current. A write to a line that other caches also hold is not answered by invalidating them. Instead, the written word is broadcast once on the bus, and each holder merges it into its own copy.

A resident line is always in one of four states: Exclusive, Shared-clean, Shared-owned or Modified. Shared-owned means that other caches hold the line and this cache must write it back on eviction. There is no invalid state for a resident line. A line that is absent is a miss.

The processor side takes one read or write at a time and answers with a one-cycle done pulse. The bus side issues three kinds of transaction: line fill, word broadcast and write-back. It samples a wired shared indication while its transaction is granted. The snoop side watches transactions from other caches. It answers combinationally with "shared" and "supply" flags and with the line data, and it applies the state change and any word merge at the next clock edge.

Top module: `upd_coh_cache`

## Requirements
- R1: After reset no line is resident. `bus_req` and `cpu_done` are low, the first access to any address misses, and a snoop of any address sees `snp_shared` low.
- R2: A read miss issues one fill (`bus_cmd` = 1). If `bus_shared` is low during the grant, the line is installed Exclusive, and a later write to it needs no bus transaction.
- R3: A read miss during which `bus_shared` is high installs the line Shared-clean, so a later write to it issues a broadcast.
- R4: A read hit on a line in any state completes with no bus transaction and returns the resident word.
- R5: A write hit on an Exclusive or Modified line merges the word locally, completes with no bus transaction and leaves the line Modified.
- R6: A write hit on a Shared-clean or Shared-owned line issues one broadcast (`bus_cmd` = 2) carrying the word and its address. The line ends Shared-owned if `bus_shared` was high during the grant, and Modified otherwise.
- R7: A write miss first fills the line. If `bus_shared` was high during that fill, a broadcast follows and the line ends Shared-owned. Otherwise the word is merged locally and the line ends Modified.
- R8: A snooped fill (`snp_cmd` = 1) that hits a resident line raises `snp_shared`. If the line is Modified or Shared-owned, `snp_supply` is also raised and `snp_line` carries the current line. Modified becomes Shared-owned, Exclusive becomes Shared-clean, and the shared states keep their state.
- R9: A snooped broadcast (`snp_cmd` = 2) that hits a resident line raises `snp_shared`, merges `snp_word` at its word offset, and leaves the line Shared-clean, so an owner gives up ownership.
- R10: A snoop whose tag does not match the resident line of its set drives `snp_shared` and `snp_supply` low and changes neither data nor state.
- R11: An address is split, from the low end, into word offset, set index and tag. A miss whose set holds a Modified or Shared-owned line issues a write-back (`bus_cmd` = 3) of the whole victim line, with its own address, before the fill. A clean victim (Exclusive or Shared-clean) is dropped silently.
- R12: If a snooped broadcast to a line arrives while this cache waits for the grant of its own broadcast to that line, the snooped word is merged first. The own broadcast is still issued, and the own word is the final value.
- R13: `bus_req`, `bus_cmd` and `bus_addr` stay unchanged until `bus_gnt`. `cpu_done` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 1 fill, 2 word broadcast, 3 write-back |
| bus_addr | output | AW | Word address of the transaction |
| bus_word | output | DW | Broadcast word |
| bus_line | output | WORDS*DW | Write-back line |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared | input | 1 | Another cache holds the line (valid with grant) |
| bus_rline | input | WORDS*DW | Fill data (valid with grant) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | 1 fill, 2 word broadcast |
| snp_addr | input | AW | Snooped word address |
| snp_word | input | DW | Snooped broadcast word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache owns the line and supplies it |
| snp_line | output | WORDS*DW | Supplied line data |

## Verification
The bench builds the block with four sets, two words per line and a six-bit address. That gives 32 lines competing for four sets, so random traffic often evicts Modified and Shared-owned victims. Every state can be reached from every other within a few operations. The bench models the other caches as one peer with a per-line presence bit, so `bus_shared` and the snoop traffic follow a coherent system. Directed sequences cover each state transition, the write-back and silent evictions, non-matching snoops and the broadcast race. They are followed by a seeded random mix of local and peer reads, writes and evictions.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

  typedef enum logic [1:0] {
    ST_E  = 2'd0,
    ST_SC = 2'd1,
    ST_SM = 2'd2,
    ST_M  = 2'd3
  } coh_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_UPD  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_WB   = 2'd1,
    F_FILL = 2'd2,
    F_UPD  = 2'd3
  } fsm_e;

  // line carries the duty to refresh memory when it leaves
  function automatic logic coh_owner(coh_st_e s);
    return (s == ST_SM) || (s == ST_M);
  endfunction

  // a processor write must be broadcast
  function automatic logic coh_write_bcast(coh_st_e s);
    return (s == ST_SC) || (s == ST_SM);
  endfunction

  function automatic coh_st_e coh_fill_st(logic shared);
    return shared ? ST_SC : ST_E;
  endfunction

  function automatic coh_st_e coh_wr_st(logic shared);
    return shared ? ST_SM : ST_M;
  endfunction

  function automatic coh_st_e coh_snoop_st(coh_st_e s, bus_cmd_e c);
    coh_st_e r;
    r = s;
    if (c == CMD_UPD) r = ST_SC;
    else if (c == CMD_RD) begin
      if (s == ST_M) r = ST_SM;
      else if (s == ST_E) r = ST_SC;
    end
    return r;
  endfunction

endpackage

// File: rtl/ucc_store.sv
module ucc_store import ucc_pkg::*; #(
  parameter int SETS  = 16,
  parameter int TAGW  = 6,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(SETS),
  localparam int OFFW = $clog2(WORDS),
  localparam int LW   = WORDS * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] a_idx,
  output logic            a_vld,
  output logic [TAGW-1:0] a_tag,
  output coh_st_e         a_st,
  output logic [LW-1:0]   a_line,
  input  logic [IDXW-1:0] b_idx,
  output logic            b_vld,
  output logic [TAGW-1:0] b_tag,
  output coh_st_e         b_st,
  output logic [LW-1:0]   b_line,
  input  logic [IDXW-1:0] w_idx,
  input  logic            w_fill,
  input  logic [TAGW-1:0] w_tag,
  input  logic [LW-1:0]   w_fline,
  input  logic            w_word_en,
  input  logic [OFFW-1:0] w_off,
  input  logic [DW-1:0]   w_word,
  input  logic            w_st_en,
  input  coh_st_e         w_st
);

  logic            vld_q [SETS];
  logic [TAGW-1:0] tag_q [SETS];
  coh_st_e         st_q  [SETS];
  logic [LW-1:0]   dat_q [SETS];

  assign a_vld  = vld_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_st   = st_q[a_idx];
  assign a_line = dat_q[a_idx];
  assign b_vld  = vld_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_st   = st_q[b_idx];
  assign b_line = dat_q[b_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        st_q[i]  <= ST_E;
        dat_q[i] <= '0;
      end
    end else begin
      if (w_fill) begin
        vld_q[w_idx] <= 1'b1;
        tag_q[w_idx] <= w_tag;
        dat_q[w_idx] <= w_fline;
      end
      // a word write in the same cycle as a fill overrides that word
      if (w_word_en) dat_q[w_idx][w_off*DW +: DW] <= w_word;
      if (w_st_en) st_q[w_idx] <= w_st;
    end
  end

endmodule

// File: rtl/ucc_snoop.sv
module ucc_snoop import ucc_pkg::*; #(
  parameter int TAGW = 6,
  parameter int LW   = 128
) (
  input  logic            snp_valid,
  input  logic [1:0]      snp_cmd,
  input  logic [TAGW-1:0] snp_tag,
  input  logic            l_vld,
  input  logic [TAGW-1:0] l_tag,
  input  coh_st_e         l_st,
  input  logic [LW-1:0]   l_line,
  output logic            hit,
  output logic            supply,
  output logic [LW-1:0]   line_out,
  output logic            merge_en,
  output coh_st_e         nxt_st
);

  bus_cmd_e cmd;
  logic     known;

  assign cmd      = bus_cmd_e'(snp_cmd);
  assign known    = (cmd == CMD_RD) || (cmd == CMD_UPD);
  assign hit      = snp_valid && known && l_vld && (l_tag == snp_tag);
  assign supply   = hit && (cmd == CMD_RD) && coh_owner(l_st);
  assign line_out = supply ? l_line : '0;
  assign merge_en = hit && (cmd == CMD_UPD);
  assign nxt_st   = coh_snoop_st(l_st, cmd);

endmodule

// File: rtl/upd_coh_cache.sv
module upd_coh_cache import ucc_pkg::*; #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int SETS  = 16,
  parameter int WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [AW-1:0]         cpu_addr,
  input  logic [DW-1:0]         cpu_wdata,
  output logic                  cpu_done,
  output logic [DW-1:0]         cpu_rdata,
  output logic                  bus_req,
  output logic [1:0]            bus_cmd,
  output logic [AW-1:0]         bus_addr,
  output logic [DW-1:0]         bus_word,
  output logic [WORDS*DW-1:0]   bus_line,
  input  logic                  bus_gnt,
  input  logic                  bus_shared,
  input  logic [WORDS*DW-1:0]   bus_rline,
  input  logic                  snp_valid,
  input  logic [1:0]            snp_cmd,
  input  logic [AW-1:0]         snp_addr,
  input  logic [DW-1:0]         snp_word,
  output logic                  snp_shared,
  output logic                  snp_supply,
  output logic [WORDS*DW-1:0]   snp_line
);

  localparam int OFFW = $clog2(WORDS);
  localparam int IDXW = $clog2(SETS);
  localparam int TAGW = AW - OFFW - IDXW;
  localparam int LW   = WORDS * DW;

  fsm_e            fsm_q;
  logic [AW-1:0]   lat_addr;
  logic            lat_we;
  logic [DW-1:0]   lat_wdata;
  logic            done_q;
  logic [DW-1:0]   rdata_q;

  // processor-side view: live request while idle, latched one otherwise
  logic [AW-1:0]   a_addr;
  logic [OFFW-1:0] a_off;
  logic [IDXW-1:0] a_idx;
  logic [TAGW-1:0] a_tagv;
  logic            a_vld;
  logic [TAGW-1:0] a_tag;
  coh_st_e         a_st;
  logic [LW-1:0]   a_line;
  logic            a_hit;

  logic [OFFW-1:0] s_off;
  logic [IDXW-1:0] s_idx;
  logic [TAGW-1:0] s_tagv;
  logic            b_vld;
  logic [TAGW-1:0] b_tag;
  coh_st_e         b_st;
  logic [LW-1:0]   b_line;
  logic            s_hit;
  logic            s_merge;
  coh_st_e         s_nst;

  // named events for the assertions
  logic accept, rd_hit_ev, wr_local_ev, gnt_wb, gnt_rd, gnt_upd, victim_dirty;

  logic            f_word_en, f_st_en;
  coh_st_e         f_st;
  logic [DW-1:0]   f_word;

  logic            w_fill, w_word_en, w_st_en;
  logic [IDXW-1:0] w_idx;
  logic [OFFW-1:0] w_off;
  logic [DW-1:0]   w_word;
  coh_st_e         w_st;

  assign a_addr = (fsm_q == F_IDLE) ? cpu_addr : lat_addr;
  assign a_off  = a_addr[OFFW-1:0];
  assign a_idx  = a_addr[OFFW +: IDXW];
  assign a_tagv = a_addr[AW-1 -: TAGW];
  assign s_off  = snp_addr[OFFW-1:0];
  assign s_idx  = snp_addr[OFFW +: IDXW];
  assign s_tagv = snp_addr[AW-1 -: TAGW];

  ucc_store #(.SETS(SETS), .TAGW(TAGW), .WORDS(WORDS), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_vld(a_vld), .a_tag(a_tag), .a_st(a_st), .a_line(a_line),
    .b_idx(s_idx), .b_vld(b_vld), .b_tag(b_tag), .b_st(b_st), .b_line(b_line),
    .w_idx(w_idx), .w_fill(w_fill), .w_tag(a_tagv), .w_fline(bus_rline),
    .w_word_en(w_word_en), .w_off(w_off), .w_word(w_word),
    .w_st_en(w_st_en), .w_st(w_st)
  );

  ucc_snoop #(.TAGW(TAGW), .LW(LW)) snoop_i (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(s_tagv),
    .l_vld(b_vld), .l_tag(b_tag), .l_st(b_st), .l_line(b_line),
    .hit(s_hit), .supply(snp_supply), .line_out(snp_line),
    .merge_en(s_merge), .nxt_st(s_nst)
  );

  assign snp_shared = s_hit;

  assign a_hit        = a_vld && (a_tag == a_tagv);
  assign victim_dirty = a_vld && coh_owner(a_st);
  // a snoop owns the store's write port, so a new access waits one cycle
  assign accept       = (fsm_q == F_IDLE) && cpu_req && !done_q && !snp_valid;
  assign rd_hit_ev    = accept && a_hit && !cpu_we;
  assign wr_local_ev  = accept && a_hit && cpu_we && !coh_write_bcast(a_st);
  assign gnt_wb       = (fsm_q == F_WB) && bus_gnt;
  assign gnt_rd       = (fsm_q == F_FILL) && bus_gnt;
  assign gnt_upd      = (fsm_q == F_UPD) && bus_gnt;

  assign f_word    = (fsm_q == F_IDLE) ? cpu_wdata : lat_wdata;
  assign f_word_en = wr_local_ev || gnt_upd || (gnt_rd && lat_we && !bus_shared);
  assign f_st_en   = wr_local_ev || gnt_upd || gnt_rd;

  always_comb begin
    if (wr_local_ev)                  f_st = ST_M;
    else if (gnt_upd)                 f_st = coh_wr_st(bus_shared);
    else if (lat_we && !bus_shared)   f_st = ST_M;
    else                              f_st = coh_fill_st(bus_shared);
  end

  // write port: a snoop hit and the processor path never coincide
  assign w_idx     = s_hit ? s_idx : a_idx;
  assign w_fill    = !s_hit && gnt_rd;
  assign w_word_en = s_hit ? s_merge : f_word_en;
  assign w_off     = s_hit ? s_off : a_off;
  assign w_word    = s_hit ? snp_word : f_word;
  assign w_st_en   = s_hit || f_st_en;
  assign w_st      = s_hit ? s_nst : f_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      lat_addr  <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (fsm_q)
        F_IDLE: if (accept) begin
          lat_addr  <= cpu_addr;
          lat_we    <= cpu_we;
          lat_wdata <= cpu_wdata;
          if (rd_hit_ev) begin
            rdata_q <= a_line[a_off*DW +: DW];
            done_q  <= 1'b1;
          end else if (wr_local_ev) begin
            done_q  <= 1'b1;
          end else if (a_hit) begin
            fsm_q   <= F_UPD;
          end else begin
            fsm_q   <= victim_dirty ? F_WB : F_FILL;
          end
        end
        F_WB: if (bus_gnt) fsm_q <= F_FILL;
        F_FILL: if (bus_gnt) begin
          if (lat_we && bus_shared) begin
            fsm_q <= F_UPD;
          end else begin
            fsm_q   <= F_IDLE;
            done_q  <= 1'b1;
            rdata_q <= bus_rline[a_off*DW +: DW];
          end
        end
        F_UPD: if (bus_gnt) begin
          fsm_q  <= F_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign bus_req   = (fsm_q != F_IDLE);
  assign bus_cmd   = (fsm_q == F_WB)   ? CMD_WB  :
                     (fsm_q == F_FILL) ? CMD_RD  :
                     (fsm_q == F_UPD)  ? CMD_UPD : CMD_NONE;
  assign bus_addr  = (fsm_q == F_WB) ? {a_tag, a_idx, {OFFW{1'b0}}} : lat_addr;
  assign bus_word  = lat_wdata;
  assign bus_line  = a_line;

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R4
  rd_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_ev |=> (cpu_done && !bus_req));

  // R5
  wr_local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_local_ev |=> (cpu_done && !bus_req));

  // R6
  upd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_upd |=> (cpu_done && !bus_req));

  // R7
  fill_then_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_rd && lat_we && bus_shared) |=> (bus_req && bus_cmd == CMD_UPD && !cpu_done));

  // R11
  wb_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_wb |=> (bus_req && bus_cmd == CMD_RD));

endmodule

// File: tb/upd_coh_cache_tb.sv
module upd_coh_cache_tb_top;
  localparam int AW = 6, DW = 16, SETS = 4, WORDS = 2;
  localparam int NW = 1 << AW;
  localparam int NL = NW / WORDS;
  localparam int LW = WORDS * DW;
  localparam int E = 0, SC = 1, SM = 2, M = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_word;
  logic [LW-1:0] bus_line;
  logic          bus_gnt = 0, bus_shared = 0;
  logic [LW-1:0] bus_rline = '0;
  logic          snp_valid = 0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_word = '0;
  logic          snp_shared, snp_supply;
  logic [LW-1:0] snp_line;

  upd_coh_cache #(.AW(AW), .DW(DW), .SETS(SETS), .WORDS(WORDS)) dut_i (.*);

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] gval [NW];
  bit peer_has [NL];
  bit ref_vld [SETS];
  int ref_tag [SETS];
  int ref_st  [SETS];

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] line_val(int line);
    logic [LW-1:0] v;
    for (int w = 0; w < WORDS; w++) v[w*DW +: DW] = gval[line*WORDS + w];
    return v;
  endfunction

  function automatic bit resident(int line);
    return ref_vld[line % SETS] && ref_tag[line % SETS] == line / SETS;
  endfunction

  // one snoop cycle; outputs checked combinationally
  task automatic snoop(int cmd, int addr, logic [DW-1:0] w, string rq);
    int line, idx;
    bit res, own;
    line = addr / WORDS; idx = line % SETS;
    res = resident(line);
    own = res && (ref_st[idx] == SM || ref_st[idx] == M);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = AW'(addr); snp_word = w;
    #1;
    chk(snp_shared == res, rq, "snp_shared", 64'(snp_shared), 64'(res));
    chk(snp_supply == (own && cmd == 1), rq, "snp_supply", 64'(snp_supply), 64'(own && cmd == 1));
    if (own && cmd == 1) chk(snp_line == line_val(line), rq, "snp_line", 64'(snp_line), 64'(line_val(line)));
    if (res) begin
      if (cmd == 2) ref_st[idx] = SC;
      else if (ref_st[idx] == E) ref_st[idx] = SC;
      else if (ref_st[idx] == M) ref_st[idx] = SM;
    end
    if (cmd == 2) gval[addr] = w;
  endtask

  task automatic peer_read(int line, string rq);
    if (peer_has[line]) return;
    @(negedge clk);
    snoop(1, line * WORDS, '0, rq);
    @(negedge clk);
    snp_valid = 0;
    peer_has[line] = 1;
  endtask

  task automatic peer_write(int addr, logic [DW-1:0] w, string rq);
    int line;
    line = addr / WORDS;
    peer_read(line, rq);
    if (resident(line)) begin
      @(negedge clk);
      snoop(2, addr, w, rq);
      @(negedge clk);
      snp_valid = 0;
    end else gval[addr] = w;
  endtask

  task automatic do_op(bit we, int addr, logic [DW-1:0] wd, bit race, logic [DW-1:0] rw, string rq);
    int line, idx, tg, st, ne, k, guard;
    int ecmd [3];
    int eline [3];
    bit hit, fin, raced;
    logic [DW-1:0] exp_rd;
    line = addr / WORDS; idx = line % SETS; tg = line / SETS;
    ne = 0; k = 0; guard = 0; fin = 0; raced = 0;
    exp_rd = gval[addr];
    hit = resident(line);
    if (!hit) begin
      if (ref_vld[idx] && (ref_st[idx] == SM || ref_st[idx] == M)) begin
        ecmd[ne] = 3; eline[ne] = ref_tag[idx] * SETS + idx; ne++;
      end
      ecmd[ne] = 1; eline[ne] = line; ne++;
      st = peer_has[line] ? SC : E;
      ref_vld[idx] = 1; ref_tag[idx] = tg;
    end else st = ref_st[idx];
    if (we) begin
      if (st == SC || st == SM) begin
        ecmd[ne] = 2; eline[ne] = line; ne++;
        st = peer_has[line] ? SM : M;
      end else st = M;
    end
    ref_st[idx] = st;

    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = wd;
    while (!fin && guard < 60) begin
      @(negedge clk);
      guard++;
      bus_gnt = 0; snp_valid = 0;
      if (cpu_done) begin
        fin = 1; cpu_req = 0;
      end else if (bus_req) begin
        if (race && bus_cmd == 2 && !raced) begin
          raced = 1;
          snoop(2, addr, rw, "R12");
          ref_st[idx] = st;
        end else begin
          chk(k < ne && int'(bus_cmd) == ecmd[k], rq, "bus_cmd", 64'(bus_cmd), 64'(k < ne ? ecmd[k] : 0));
          if (k < ne) begin
            chk(int'(bus_addr) / WORDS == eline[k], rq, "bus line addr", 64'(bus_addr), 64'(eline[k] * WORDS));
            if (bus_cmd == 3)
              chk(bus_line == line_val(eline[k]), "R11", "writeback data", 64'(bus_line), 64'(line_val(eline[k])));
            if (bus_cmd == 2) begin
              chk(int'(bus_addr) == addr, rq, "bcast addr", 64'(bus_addr), 64'(addr));
              chk(bus_word == wd, rq, "bcast word", 64'(bus_word), 64'(wd));
            end
          end
          bus_shared = (bus_cmd == 3) ? 1'b0 : peer_has[line];
          bus_rline = line_val(line);
          bus_gnt = 1;
          k++;
        end
      end
    end
    chk(fin, "R13", "access completed", 64'(fin), 64'd1);
    chk(k == ne, rq, "bus transaction count", 64'(k), 64'(ne));
    if (!we) chk(cpu_rdata == exp_rd, rq, "read data", 64'(cpu_rdata), 64'(exp_rd));
    else gval[addr] = wd;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int r, a;
    void'($urandom(32'd4242));
    for (int i = 0; i < NW; i++) gval[i] = DW'(16'hA000 + i);
    for (int i = 0; i < NL; i++) peer_has[i] = 0;
    for (int i = 0; i < SETS; i++) begin ref_vld[i] = 0; ref_tag[i] = 0; ref_st[i] = E; end
    repeat (3) @(negedge clk);
    // R1: idle outputs under reset
    chk(bus_req == 0, "R1", "bus_req in reset", 64'(bus_req), 0);
    chk(cpu_done == 0, "R1", "cpu_done in reset", 64'(cpu_done), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: nothing resident, snoop misses
    snoop(1, 0, '0, "R1");
    @(negedge clk); snp_valid = 0;

    do_op(0, 0, '0, 0, '0, "R2");          // miss, no sharer -> E
    do_op(0, 1, '0, 0, '0, "R4");          // read hit
    do_op(1, 0, 16'h1111, 0, '0, "R5");    // E -> M silent
    do_op(1, 1, 16'h2222, 0, '0, "R5");    // M stays M silent
    peer_read(0, "R8");                    // supply, M -> SM
    do_op(1, 1, 16'h3333, 0, '0, "R6");    // SM bcast shared -> SM
    peer_read(0, "R8");
    @(negedge clk); snoop(1, 0, '0, "R8"); @(negedge clk); snp_valid = 0; // SM keeps supplying
    peer_write(0, 16'h4444, "R9");         // merge, SM -> SC
    do_op(0, 0, '0, 0, '0, "R9");          // merged word visible
    peer_has[0] = 0;
    do_op(1, 0, 16'h5555, 0, '0, "R6");    // SC bcast, no sharer -> M
    @(negedge clk); snoop(2, 8, 16'h7777, "R10"); @(negedge clk); snp_valid = 0;
    @(negedge clk); snoop(1, 24, '0, "R10"); @(negedge clk); snp_valid = 0;
    do_op(0, 0, '0, 0, '0, "R10");         // own word unchanged
    do_op(0, 8, '0, 0, '0, "R11");         // dirty victim -> WB then fill
    do_op(0, 16, '0, 0, '0, "R11");        // clean victim -> fill only
    peer_read(5, "R3");
    do_op(0, 10, '0, 0, '0, "R3");         // shared fill -> SC
    do_op(1, 11, 16'h6666, 0, '0, "R3");   // SC write -> bcast
    peer_read(6, "R7");
    do_op(1, 12, 16'h8888, 0, '0, "R7");   // write miss shared -> fill + bcast
    do_op(1, 14, 16'h9999, 0, '0, "R7");   // write miss alone -> fill only
    do_op(0, 14, '0, 0, '0, "R7");
    peer_read(9, "R12");
    do_op(0, 18, '0, 0, '0, "R12");
    do_op(1, 18, 16'hBEEF, 1, 16'hCAFE, "R12");
    do_op(0, 18, '0, 0, '0, "R12");

    for (int n = 0; n < 600; n++) begin
      r = $urandom_range(99, 0);
      a = $urandom_range(NW - 1, 0);
      if (r < 35)      do_op(0, a, '0, 0, '0, "R4");
      else if (r < 65) do_op(1, a, DW'($urandom), 0, '0, "R6");
      else if (r < 75) peer_read(a / WORDS, "R8");
      else if (r < 90) peer_write(a, DW'($urandom), "R9");
      else             peer_has[a / WORDS] = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule